// File: doc/BRIEF.md
# Single-Precision Floating-Point Adder

This unit adds two 32-bit binary floating-point operands. Each operand carries a sign in bit 31, an 8-bit exponent with a bias of 127 in bits 30:23, and a 23-bit fraction in bits 22:0. The unit splits both words into these fields and puts back the hidden leading one on normal values. It then shifts the mantissa of the operand with the smaller exponent right by the exponent gap, adds the two mantissas, renormalizes the sum, rounds it to the nearest value with ties to even, and packs the result.

All of this is one combinational cone, and one output register closes it. A result appears exactly one clock after its operands. Operand pairs may be presented on every cycle. NaN, infinity and zero encodings are detected ahead of the datapath and resolved by a priority mux. The arithmetic path covers operands of equal sign. For opposite-sign finite operands the result is unspecified.

Top module: `fp32_add_unit`

## Requirements
- R1: A pair sampled with `in_valid` high produces `out_valid` high and its `result` on the next clock edge. A cycle with `in_valid` low produces `out_valid` low on the next edge. A synchronous reset clears `out_valid` and `result` to 0.
- R2: Words use sign bit 31, biased exponent bits 30:23 (bias 127) and fraction bits 22:0. An exponent of 1 to 254 implies a leading 1 ahead of the fraction, so 0x3FC00000 + 0x3FC00000 = 0x40400000.
- R3: The mantissa of the operand with the smaller exponent is shifted right by the exponent difference. Operand order does not matter: 0x40500000 + 0x3FC00000 = 0x40980000.
- R4: A mantissa sum of 2 or more is shifted right by one and the exponent is incremented. Examples: 0x3FC00000 + 0x40500000 = 0x40980000 and 0x3F800000 + 0x3F800000 = 0x40000000.
- R5: For operands of equal sign, the result carries that sign: 0xBFC00000 + 0xC0500000 = 0xC0980000.
- R6: Rounding is to nearest with ties to even. Guard, round and sticky bits are kept through alignment. Below half rounds down (0x3F800000 + 0x33000000 = 0x3F800000). Above half rounds up (0x3F800000 + 0x33800001 = 0x3F800001). An exact half goes to the even neighbour (0x3F800000 + 0x33800000 = 0x3F800000; 0x3F800001 + 0x33800000 = 0x3F800002). A far-smaller operand only sets sticky (0x3F800000 + 0x0D800000 = 0x3F800000).
- R7: A rounding carry out of the mantissa renormalizes a second time: 0x3FFFFFFF + 0x33800000 = 0x40000000.
- R8: A final exponent above 254 gives infinity of the result sign: 0x7F7FFFFF + 0x7F7FFFFF = 0x7F800000 and 0xFF7FFFFF + 0xFF7FFFFF = 0xFF800000.
- R9: Exponent 255 with a nonzero fraction is NaN. Any NaN operand, and infinities of opposite sign, give the quiet NaN 0x7FC00000.
- R10: Exponent 255 with a zero fraction is infinity. Infinity plus a finite value, or plus an infinity of the same sign, returns that infinity: 0x7F800000 + 0x3F800000 = 0x7F800000 and 0xBF800000 + 0xFF800000 = 0xFF800000.
- R11: An operand with exponent 0 counts as zero and has no implicit 1. If X is zero the result is Y; otherwise, if Y is zero, the result is X.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand pair present this cycle |
| op_x | input | 32 | First operand |
| op_y | input | 32 | Second operand |
| out_valid | output | 1 | Result present this cycle |
| result | output | 32 | Registered sum |

## Verification
The bench targets three kinds of corner cases:
- **Rounding.** It probes the three positions just below half, above half and at exactly half, on both an even and an odd least significant bit. A design that drops the sticky bit rounds the above-half case down. A design that ignores ties to even rounds 0x3F800000 + 0x33800000 up.
- **Carries.** It drives an all-ones mantissa into a rounding carry, and two maximal finite values into exponent overflow. A missing second renormalization shows as a garbage exponent or fraction. A missing overflow check shows as a NaN-looking word instead of infinity.
- **Special encodings and operand order.** NaN, infinity and zero inputs, plus swapped operand order, catch a broken priority mux or a wrong swap in alignment.

// File: rtl/fpadd_pkg.sv
package fpadd_pkg;
    localparam int EXP_W  = 8;
    localparam int FRAC_W = 23;
    localparam int WORD_W = 1 + EXP_W + FRAC_W;
    localparam int MANT_W = FRAC_W + 1;
    localparam int GRS_W  = 3;
    localparam int EXT_W  = MANT_W + GRS_W;
    localparam int BIAS   = (1 << (EXP_W - 1)) - 1;

    localparam logic [EXP_W-1:0]  EXP_ALL1 = '1;
    localparam logic [WORD_W-1:0] QNAN_WORD = {1'b0, EXP_ALL1, 1'b1, {(FRAC_W-1){1'b0}}};

    typedef struct packed {
        logic              sign;
        logic [EXP_W-1:0]  exp;
        logic [FRAC_W-1:0] frac;
    } fp_word_t;

    typedef enum logic [1:0] {
        CLS_ZERO = 2'd0,
        CLS_NORM = 2'd1,
        CLS_INF  = 2'd2,
        CLS_NAN  = 2'd3
    } fp_class_t;

    typedef struct packed {
        logic              sign;
        logic [EXP_W-1:0]  exp;
        logic [MANT_W-1:0] mant;
        fp_class_t         cls;
    } fp_unpacked_t;

    function automatic fp_class_t classify(input fp_word_t w);
        if (w.exp == EXP_ALL1)
            return (w.frac == '0) ? CLS_INF : CLS_NAN;
        else if (w.exp == '0)
            return CLS_ZERO;
        else
            return CLS_NORM;
    endfunction
endpackage

// File: rtl/fp_unpack.sv
module fp_unpack
    import fpadd_pkg::*;
(
    input  fp_word_t     w,
    output fp_unpacked_t u
);
    always_comb begin
        u.sign = w.sign;
        u.exp  = w.exp;
        u.mant = {(w.exp != '0), w.frac};
        u.cls  = classify(w);
    end
endmodule

// File: rtl/fp_align.sv
module fp_align
    import fpadd_pkg::*;
(
    input  fp_unpacked_t     a,
    input  fp_unpacked_t     b,
    output logic             big_sign,
    output logic [EXP_W-1:0] big_exp,
    output logic [EXT_W-1:0] big_ext,
    output logic [EXT_W-1:0] small_ext
);
    localparam logic [EXP_W-1:0] SHIFT_CAP = EXP_W'(EXT_W);

    fp_unpacked_t     hi, lo;
    logic [EXP_W-1:0] diff;
    logic [EXT_W-1:0] wide, shifted, mask;
    logic             sticky;

    always_comb begin
        if (b.exp > a.exp) begin
            hi = b;
            lo = a;
        end else begin
            hi = a;
            lo = b;
        end
        diff = hi.exp - lo.exp;
        wide = {lo.mant, {GRS_W{1'b0}}};
        if (diff >= SHIFT_CAP) begin
            shifted = '0;
            mask    = '1;
        end else begin
            shifted = wide >> diff;
            mask    = (EXT_W'(1) << diff) - EXT_W'(1);
        end
        sticky    = |(wide & mask);
        small_ext = {shifted[EXT_W-1:1], shifted[0] | sticky};
        big_ext   = {hi.mant, {GRS_W{1'b0}}};
        big_exp   = hi.exp;
        big_sign  = hi.sign;
    end
endmodule

// File: rtl/fp_addnorm.sv
module fp_addnorm
    import fpadd_pkg::*;
(
    input  logic             sign,
    input  logic [EXP_W-1:0] exp_in,
    input  logic [EXT_W-1:0] big_ext,
    input  logic [EXT_W-1:0] small_ext,
    output fp_word_t         res
);
    logic [EXT_W:0]    sum;
    logic [EXT_W-1:0]  norm;
    logic [EXP_W:0]    e1, e2;
    logic              up;
    logic [MANT_W:0]   rnd;
    logic [FRAC_W-1:0] frac;

    always_comb begin
        sum = {1'b0, big_ext} + {1'b0, small_ext};
        if (sum[EXT_W]) begin
            norm = {sum[EXT_W:2], sum[1] | sum[0]};
            e1   = {1'b0, exp_in} + {{EXP_W{1'b0}}, 1'b1};
        end else begin
            norm = sum[EXT_W-1:0];
            e1   = {1'b0, exp_in};
        end
        // guard = norm[2], round = norm[1], sticky = norm[0], lsb = norm[3]
        up  = norm[2] & (norm[1] | norm[0] | norm[3]);
        rnd = {1'b0, norm[EXT_W-1:GRS_W]} + {{MANT_W{1'b0}}, up};
        if (rnd[MANT_W]) begin
            e2   = e1 + {{EXP_W{1'b0}}, 1'b1};
            frac = '0;
        end else begin
            e2   = e1;
            frac = rnd[FRAC_W-1:0];
        end
        if (e2 >= {1'b0, EXP_ALL1})
            res = '{sign: sign, exp: EXP_ALL1, frac: '0};
        else
            res = '{sign: sign, exp: e2[EXP_W-1:0], frac: frac};
    end

    // R4: a normal larger operand leaves a normalized sum
    always_comb begin
        if (big_ext[EXT_W-1])
            a_r4_norm_msb: assert (norm[EXT_W-1]);
    end
endmodule

// File: rtl/fp32_add_unit.sv
module fp32_add_unit
    import fpadd_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic [31:0] op_x,
    input  logic [31:0] op_y,
    output logic        out_valid,
    output logic [31:0] result
);
    logic [WORD_W-1:0] ops [2];
    fp_unpacked_t      un  [2];

    assign ops[0] = op_x;
    assign ops[1] = op_y;

    for (genvar i = 0; i < 2; i++) begin : g_unp
        fp_unpack u_unp (.w(ops[i]), .u(un[i]));
    end

    logic             big_sign;
    logic [EXP_W-1:0] big_exp;
    logic [EXT_W-1:0] big_ext, small_ext;
    fp_word_t         sum_word;
    logic [31:0]      nxt;

    fp_align u_align (
        .a(un[0]), .b(un[1]),
        .big_sign(big_sign), .big_exp(big_exp),
        .big_ext(big_ext), .small_ext(small_ext)
    );

    fp_addnorm u_addnorm (
        .sign(big_sign), .exp_in(big_exp),
        .big_ext(big_ext), .small_ext(small_ext),
        .res(sum_word)
    );

    always_comb begin
        if (un[0].cls == CLS_NAN || un[1].cls == CLS_NAN)
            nxt = QNAN_WORD;
        else if (un[0].cls == CLS_INF && un[1].cls == CLS_INF)
            nxt = (un[0].sign != un[1].sign) ? QNAN_WORD : op_x;
        else if (un[0].cls == CLS_INF)
            nxt = op_x;
        else if (un[1].cls == CLS_INF)
            nxt = op_y;
        else if (un[0].cls == CLS_ZERO)
            nxt = op_y;
        else if (un[1].cls == CLS_ZERO)
            nxt = op_x;
        else
            nxt = sum_word;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            result    <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid)
                result <= nxt;
        end
    end

    // R1: one-cycle latency
    a_r1_valid_follow: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    a_r1_idle: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    // R9: NaN input gives the quiet NaN
    a_r9_nan_in: assert property (@(posedge clk) disable iff (rst)
        in_valid && op_x[30:23] == 8'hFF && op_x[22:0] != 23'd0
        |=> result == QNAN_WORD);
    // R10: infinity plus finite keeps the infinity
    a_r10_inf_keep: assert property (@(posedge clk) disable iff (rst)
        in_valid && op_x[30:23] == 8'hFF && op_x[22:0] == 23'd0 && op_y[30:23] != 8'hFF
        |=> result == {$past(op_x[31]), 8'hFF, 23'd0});
    // R5: equal signs keep the sign
    a_r5_sign: assert property (@(posedge clk) disable iff (rst)
        in_valid && op_x[31] == op_y[31]
        |=> (result == QNAN_WORD) || (result[31] == $past(op_x[31])));
    // R8: an all-ones exponent is only infinity or the quiet NaN
    a_r8_no_bad_top: assert property (@(posedge clk) disable iff (rst)
        out_valid && result[30:23] == 8'hFF |-> result[22:0] == 23'd0 || result == QNAN_WORD);
endmodule

// File: tb/tb_fp32_add_unit.sv
`timescale 1ns/1ps
module tb_fp32_add_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] op_x = '0;
    logic [31:0] op_y = '0;
    logic        out_valid;
    logic [31:0] result;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [31:0] exp_q [$];
    string       tag_q [$];

    always #10 clk = ~clk;

    fp32_add_unit dut (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .op_x(op_x), .op_y(op_y),
        .out_valid(out_valid), .result(result)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
        n_checks++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s: actual %08h expected %08h", tag, act, expv);
        end
    endtask

    task automatic send(input logic [31:0] x, input logic [31:0] y,
                        input logic [31:0] expv, input string tag);
        @(negedge clk);
        in_valid = 1'b1;
        op_x     = x;
        op_y     = y;
        exp_q.push_back(expv);
        tag_q.push_back(tag);
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // monitor: pops expected items as results appear
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (exp_q.size() == 0) begin
                check("R1 unexpected out_valid", 32'd1, 32'd0);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, result, e);
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset out_valid", {31'd0, out_valid}, 32'd0);
        check("R1 reset result", result, 32'd0);
        rst = 1'b0;

        send(32'h3FC00000, 32'h40500000, 32'h40980000, "R4 example sum");
        send(32'h40500000, 32'h3FC00000, 32'h40980000, "R3 swapped order");
        send(32'h3F800000, 32'h3F800000, 32'h40000000, "R4 equal exponents");
        send(32'h3FC00000, 32'h3FC00000, 32'h40400000, "R2 hidden one");
        send(32'hBFC00000, 32'hC0500000, 32'hC0980000, "R5 negative sum");
        idle();
        @(negedge clk);
        check("R1 idle out_valid", {31'd0, out_valid}, 32'd0);
        send(32'h3F800000, 32'h33000000, 32'h3F800000, "R6 below half");
        send(32'h3F800000, 32'h33800001, 32'h3F800001, "R6 above half");
        send(32'h3F800000, 32'h33800000, 32'h3F800000, "R6 tie even stays");
        send(32'h3F800001, 32'h33800000, 32'h3F800002, "R6 tie odd up");
        send(32'h3F800000, 32'h0D800000, 32'h3F800000, "R6 far sticky");
        send(32'h3FFFFFFF, 32'h33800000, 32'h40000000, "R7 round carry");
        send(32'h7F7FFFFF, 32'h7F7FFFFF, 32'h7F800000, "R8 overflow pos");
        send(32'hFF7FFFFF, 32'hFF7FFFFF, 32'hFF800000, "R8 overflow neg");
        send(32'h7FC00001, 32'h3F800000, 32'h7FC00000, "R9 nan x");
        send(32'h3F800000, 32'h7F800001, 32'h7FC00000, "R9 nan y");
        send(32'h7F800000, 32'hFF800000, 32'h7FC00000, "R9 inf minus inf");
        send(32'h7F800000, 32'h3F800000, 32'h7F800000, "R10 inf plus finite");
        send(32'hBF800000, 32'hFF800000, 32'hFF800000, "R10 neg inf y");
        send(32'h00000000, 32'h40500000, 32'h40500000, "R11 zero x");
        send(32'h3FC00000, 32'h00000000, 32'h3FC00000, "R11 zero y");
        idle();
        repeat (3) @(negedge clk);
        check("R1 drained out_valid", {31'd0, out_valid}, 32'd0);
        check("R1 queue empty", exp_q.size(), 32'd0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(20 * 5000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule